// File: doc/BRIEF.md
# SPI Master with Split Transmit and Total Byte Counts

This block is a register-driven SPI master that moves whole bytes in SPI mode 0. Software fills a small byte buffer, picks a serial clock rate in a configuration register, and then writes one command word. The command names a chip select, says whether that chip select stays asserted after the transfer, and gives two counts: how many bytes are driven from the buffer, and how many byte times are clocked in total.

During byte time k the engine shifts slot k out on MOSI while it shifts the slave's answer in from MISO. The answer then replaces slot k in the same buffer. Byte times past the transmit count drive zeros but still receive. A full-duplex exchange and a short command followed by a read phase therefore use the same mechanism. Busy, done and error flags show the state of the engine at the ports and in a status register.

Register map: address 0 holds the clock divider in bits [7:0]. Address 1 is the command register and can only be written. Address 2 is the read-only status register. Addresses SLOTS..2*SLOTS-1 are the buffer slots, one byte each, in bits [7:0]. SLOTS must be a power of two and at least 4.

Top module: `spi_split_master`

## Requirements
- R1: After reset, busy, done and the error flag read 0 and the divider reads 0. Every chip-select line is high, and SCLK and MOSI are low.
- R2: In the command word, bits [7:0] are the total byte count, bits [15:8] the transmit byte count, bit 16 the hold flag and bits [21:20] the chip-select index. While busy, only the indexed active-low chip select is low.
- R3: Each byte time produces exactly 8 rising SCLK edges. Each SCLK half period lasts (divider + 1) system clocks, so busy stays high for 16 × total × (divider + 1) clocks.
- R4: Byte times 0 to TX-1 drive buffer slots 0 to TX-1 in that order, most significant bit first. Later byte times drive 0x00.
- R5: The byte received in byte time k overwrites slot k. Slots at and above the total count keep their contents.
- R6: When the last byte completes, the chip select is released, unless the hold flag was set. With the hold flag set, it stays low until the next accepted command.
- R7: A command with total = 0, with TX > total, or with total > SLOTS starts nothing and sets the error flag (status bit 2). The next accepted command clears the flag.
- R8: Busy (status bit 0) rises on the clock edge that accepts a command and falls when the last byte ends. On that same edge done (status bit 1) is set. Done stays set until the next accepted command.
- R9: While busy, writes to the buffer, to the divider and to the command register are ignored.
- R10: SCLK idles low. MOSI changes only as a transfer starts or as SCLK falls. MISO is sampled as SCLK rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | $clog2(SLOTS)+1 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | CS_NUM | Active-low chip selects |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| cmdErr | output | 1 | Last command was rejected |

## Verification
The assertions take for granted that MISO is stable around every rising SCLK edge. They also take for granted that software does not expect a write to have any effect while busy is high. The bench's slave model updates MISO only half a system clock after it sees SCLK fall, so each sample is taken well away from a change. Buffer, divider and command writes issued while busy are there to show that they are dropped. Any result that depends on such a write is checked only after busy has fallen.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Strobes the control sends to the datapath on a single clock.
  typedef struct packed {
    logic loadTx;    // reload the transmit shifter
    logic loadZero;  // reload it with 0x00 instead of a buffer slot
    logic shiftTx;   // move the transmit shifter by one bit
    logic sampleRx;  // capture MISO into the receive shifter
    logic writeRx;   // store the received byte into its slot
  } dpCtl_t;

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3,
  parameter int CS_NUM = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [DIV_W-1:0]  cfgData,
  input  logic              cmdWr,
  input  logic [7:0]        cmdTot,
  input  logic [7:0]        cmdTx,
  input  logic              cmdHold,
  input  logic [1:0]        cmdCs,
  output dpCtl_t            ctl,
  output logic [SLOT_W-1:0] txSlot,
  output logic [SLOT_W-1:0] rxSlot,
  output logic              sclk,
  output logic [CS_NUM-1:0] csN,
  output logic              busy,
  output logic              done,
  output logic              cmdErr,
  output logic [DIV_W-1:0]  divReg
);

  localparam int CNT_W = SLOT_W + 1;

  logic             busyR, doneR, errR, sclkR, holdR, csOn;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] byteCnt, totR, txR, nextByte;
  logic [1:0]       csIdxR;
  logic             cmdOk, start, reject, tick, lastBit, lastByte;

  assign cmdOk    = (cmdTot != 8'd0) && (cmdTx <= cmdTot) && (cmdTot <= 8'(SLOTS));
  assign start    = cmdWr && !busyR && cmdOk;
  assign reject   = cmdWr && !busyR && !cmdOk;
  assign tick     = busyR && (divCnt == divReg);
  assign lastBit  = (bitCnt == 3'd7);
  assign nextByte = byteCnt + CNT_W'(1);
  assign lastByte = (nextByte == totR);

  always_comb begin
    ctl    = '0;
    txSlot = '0;
    rxSlot = SLOT_W'(byteCnt);
    if (start) begin
      ctl.loadTx   = 1'b1;
      ctl.loadZero = (cmdTx == 8'd0);
    end else if (tick) begin
      if (!sclkR) begin
        ctl.sampleRx = 1'b1;
      end else if (lastBit) begin
        ctl.writeRx = 1'b1;
        if (!lastByte) begin
          ctl.loadTx   = 1'b1;
          ctl.loadZero = (nextByte >= txR);
          txSlot       = SLOT_W'(nextByte);
        end
      end else begin
        ctl.shiftTx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      errR    <= 1'b0;
      sclkR   <= 1'b0;
      holdR   <= 1'b0;
      csOn    <= 1'b0;
      divCnt  <= '0;
      divReg  <= '0;
      bitCnt  <= '0;
      byteCnt <= '0;
      totR    <= '0;
      txR     <= '0;
      csIdxR  <= '0;
    end else begin
      if (cfgWr && !busyR) divReg <= cfgData;
      if (start) begin
        busyR   <= 1'b1;
        doneR   <= 1'b0;
        errR    <= 1'b0;
        sclkR   <= 1'b0;
        divCnt  <= '0;
        bitCnt  <= '0;
        byteCnt <= '0;
        totR    <= CNT_W'(cmdTot);
        txR     <= CNT_W'(cmdTx);
        holdR   <= cmdHold;
        csIdxR  <= cmdCs;
        csOn    <= 1'b1;
      end else if (reject) begin
        errR <= 1'b1;
      end else if (busyR) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (!sclkR) begin
            sclkR <= 1'b1;
          end else begin
            sclkR <= 1'b0;
            if (lastBit) begin
              bitCnt <= '0;
              if (lastByte) begin
                busyR <= 1'b0;
                doneR <= 1'b1;
                csOn  <= holdR;
              end else begin
                byteCnt <= nextByte;
              end
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign csN[i] = !(csOn && (csIdxR == 2'(i)));
  end

  assign sclk   = sclkR;
  assign busy   = busyR;
  assign done   = doneR;
  assign cmdErr = errR;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk) else $error("sclk high while idle"); // R10
  AST_CS_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (csN != '1)) else $error("no chip select while busy"); // R2
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done) else $error("busy fell without done"); // R8
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> !busy) else $error("rejected command started"); // R7
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !holdR) |-> (csN == '1)) else $error("cs not released"); // R6

endmodule

// File: rtl/spim_dpath.sv
module spim_dpath
  import spim_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SLOT_W-1:0] txSlot,
  input  logic [SLOT_W-1:0] rxSlot,
  input  logic              bufWr,
  input  logic [SLOT_W-1:0] bufIdx,
  input  logic [7:0]        bufData,
  output logic [7:0]        bufRd,
  input  logic              miso,
  output logic              mosi
);

  logic [7:0] slotMem [SLOTS];
  logic [7:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slotMem[i] <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (bufWr) slotMem[bufIdx] <= bufData;
      if (ctl.writeRx) slotMem[rxSlot] <= rxShift;
      if (ctl.sampleRx) rxShift <= {rxShift[6:0], miso};
      if (ctl.loadTx) txShift <= ctl.loadZero ? 8'h00 : slotMem[txSlot];
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign bufRd = slotMem[bufIdx];
  assign mosi  = txShift[7];

  AST_NO_DUAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadTx && ctl.shiftTx)) else $error("load and shift together"); // R4
  AST_NO_BUF_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(bufWr && ctl.writeRx)) else $error("buffer write during transfer"); // R9

endmodule

// File: rtl/spi_split_master.sv
module spi_split_master
  import spim_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int CS_NUM = 4,
  parameter int DIV_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [$clog2(SLOTS):0]     regAddr,
  input  logic [31:0]                regWrData,
  output logic [31:0]                regRdData,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic [CS_NUM-1:0]          csN,
  output logic                       busy,
  output logic                       done,
  output logic                       cmdErr
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ADDR_W = SLOT_W + 1;

  dpCtl_t            ctl;
  logic [SLOT_W-1:0] txSlot, rxSlot, bufIdx;
  logic [7:0]        bufRd;
  logic [DIV_W-1:0]  divReg;
  logic              isBuf, cfgWr, cmdWr, bufWr, unusedWrBits;

  assign isBuf  = regAddr[ADDR_W-1];
  assign bufIdx = regAddr[SLOT_W-1:0];
  assign cfgWr  = regWrEn && (regAddr == ADDR_W'(0));
  assign cmdWr  = regWrEn && (regAddr == ADDR_W'(1));
  assign bufWr  = regWrEn && isBuf && !busy;
  assign unusedWrBits = ^{regWrData[31:22], regWrData[19:17]};

  spim_ctrl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CS_NUM(CS_NUM), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgData(regWrData[DIV_W-1:0]),
    .cmdWr(cmdWr), .cmdTot(regWrData[7:0]), .cmdTx(regWrData[15:8]),
    .cmdHold(regWrData[16]), .cmdCs(regWrData[21:20]),
    .ctl(ctl), .txSlot(txSlot), .rxSlot(rxSlot),
    .sclk(sclk), .csN(csN), .busy(busy), .done(done), .cmdErr(cmdErr),
    .divReg(divReg)
  );

  spim_dpath #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txSlot(txSlot), .rxSlot(rxSlot),
    .bufWr(bufWr), .bufIdx(bufIdx), .bufData(regWrData[7:0]), .bufRd(bufRd),
    .miso(miso), .mosi(mosi)
  );

  always_comb begin
    regRdData = '0;
    if (isBuf) begin
      regRdData[7:0] = bufRd;
    end else if (regAddr == ADDR_W'(0)) begin
      regRdData[DIV_W-1:0] = divReg;
    end else if (regAddr == ADDR_W'(2)) begin
      regRdData[2:0] = {cmdErr, done, busy};
    end
  end

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi))
    else $error("mosi moved away from a falling sclk"); // R10

endmodule

// File: tb/test_spi_split_master.sv
module test_spi_split_master;
  localparam int SLOTS = 8;
  localparam int CS_NUM = 4;
  localparam int AW = $clog2(SLOTS) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sclk, mosi, busy, done, cmdErr;
  logic miso = 1'b0;
  logic [CS_NUM-1:0] csN;

  always #10 clk = ~clk;

  spi_split_master #(.SLOTS(SLOTS), .CS_NUM(CS_NUM)) i_spi_split_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .busy(busy), .done(done), .cmdErr(cmdErr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural slave and per-clock reference
  logic [7:0] resp [SLOTS];
  logic [7:0] seenMosi [SLOTS];
  logic [7:0] txb [SLOTS];
  int slvBit = 0, riseCnt = 0, busyCnt = 0;
  logic prevSclk = 1'b0;
  logic [CS_NUM-1:0] expBusyCs = '1, expIdleCs = '1, pendIdle = '1;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        busyCnt++;
        chk(csN == expBusyCs, "R2", "csN while busy", csN, expBusyCs);
        expIdleCs = pendIdle;
      end else begin
        chk(csN == expIdleCs, "R6", "csN while idle", csN, expIdleCs);
        chk(sclk == 1'b0, "R10", "sclk idle", sclk, 0);
      end
      if (sclk && !prevSclk) begin
        if (riseCnt / 8 < SLOTS)
          seenMosi[riseCnt/8] = {seenMosi[riseCnt/8][6:0], mosi};
        riseCnt++;
      end
      if (!sclk && prevSclk) begin
        slvBit++;
        miso = (slvBit / 8 < SLOTS) ? resp[slvBit/8][7 - slvBit%8] : 1'b0;
      end
    end
    prevSclk = sclk;
  end

  task automatic regWrite(int a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = AW'(a);
    #1 d = regRdData;
  endtask

  task automatic runXfer(int dv, int sel, bit hold, int tx, int tot, bit poke);
    logic [31:0] rd;
    int cyc;
    regWrite(0, 32'(dv));
    for (int i = 0; i < SLOTS; i++) begin
      txb[i] = 8'((8'hA3 + i * 7) ^ sel);
      resp[i] = 8'(8'h3C + i * 29 + dv);
      seenMosi[i] = 8'h00;
      regWrite(SLOTS + i, {24'h0, txb[i]});
    end
    slvBit = 0; riseCnt = 0; busyCnt = 0;
    miso = resp[0][7];
    expBusyCs = ~(CS_NUM'(1) << sel);
    pendIdle = hold ? expBusyCs : '1;
    regWrite(1, {10'b0, 2'(sel), 3'b0, hold, 8'(tx), 8'(tot)});
    chk(busy == 1'b1, "R8", "busy after command", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      regWrite(SLOTS + 5, 32'hEE);   // R9 ignored buffer write
      regWrite(0, 32'(dv + 3));      // R9 ignored divider write
      regWrite(1, 32'h0000_0101);    // R9 ignored command write
    end
    cyc = 0;
    while (busy && cyc < 50000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 50000, "R8", "transfer watchdog", cyc, 0);
    chk(done == 1'b1, "R8", "done flag", done, 1);
    regRead(2, rd);
    chk(rd[2:0] == 3'b010, "R7", "status after accepted command", rd[2:0], 3'b010);
    chk(riseCnt == 8 * tot, "R3", "sclk rising edges", riseCnt, 8 * tot);
    chk(busyCnt == 16 * tot * (dv + 1), "R3", "busy cycles", busyCnt, 16 * tot * (dv + 1));
    for (int k = 0; k < tot; k++)
      chk(seenMosi[k] == ((k < tx) ? txb[k] : 8'h00), "R4", "mosi byte", seenMosi[k],
          (k < tx) ? txb[k] : 8'h00);
    for (int k = 0; k < SLOTS; k++) begin
      regRead(SLOTS + k, rd);
      if (k < tot) chk(rd[7:0] == resp[k], "R5", "received slot", rd[7:0], resp[k]);
      else chk(rd[7:0] == txb[k], poke ? "R9" : "R5", "untouched slot", rd[7:0], txb[k]);
    end
    if (poke) begin
      regRead(0, rd);
      chk(rd[7:0] == 8'(dv), "R9", "divider kept", rd[7:0], dv);
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R9", "no second start", busy, 0);
    end
    chk(csN == pendIdle, "R6", "cs after end", csN, pendIdle);
  endtask

  task automatic badCmd(int tx, int tot);
    logic [31:0] rd;
    regWrite(1, {10'b0, 2'd1, 3'b0, 1'b0, 8'(tx), 8'(tot)});
    regRead(2, rd);
    chk(rd[2:0] == 3'b100 || rd[2:0] == 3'b110, "R7", "error set, not busy", rd[2:0], 3'b110);
    chk(csN == expIdleCs, "R7", "cs unchanged", csN, expIdleCs);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead(2, rd);
    chk(rd[2:0] == 3'b000, "R1", "status after reset", rd[2:0], 0);
    regRead(0, rd);
    chk(rd == 32'h0, "R1", "divider after reset", rd, 0);
    chk(csN == '1, "R1", "csN after reset", csN, 4'hF);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1", "sclk/mosi after reset", {sclk, mosi}, 0);

    runXfer(0, 1, 1'b0, 3, 3, 1'b0);  // full duplex
    runXfer(1, 1, 1'b0, 2, 3, 1'b0);  // command then read phase
    runXfer(2, 0, 1'b0, 0, 2, 1'b0);  // receive only
    runXfer(0, 3, 1'b0, 8, 8, 1'b0);  // whole buffer
    badCmd(0, 0);                     // R7 total zero
    badCmd(3, 2);                     // R7 tx above total
    badCmd(1, 9);                     // R7 total above slots
    runXfer(3, 1, 1'b1, 1, 1, 1'b0);  // R6 hold chip select
    chk(csN == 4'b1101, "R6", "held cs", csN, 4'b1101);
    runXfer(1, 2, 1'b0, 1, 4, 1'b1);  // R9 writes while busy

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule